// File: doc/BRIEF.md
# Flash-to-Parallel Configuration Loader

This block boots a target programmable device from a 16-bit parallel flash. When reset is released, or whenever the active-low reconfigure button is pressed, it pulls the target's configuration-reset pin low for a set time. It then releases the pin and waits for the target to report that it is ready. A page selector, sampled when the load starts, picks one of two image regions in flash: the factory region or the user region. The block reads that region one 16-bit word at a time and sends each word to the target as two bytes, each qualified by a rising edge of the configuration clock.

The flash side is a pair of valid/ready streams. The request stream carries a byte address, and only one request is outstanding at a time. The response stream carries the data word. When the flash holds the request ready low, the request stays valid and its address stays unchanged. The loader raises its response ready only while it waits for a word, so the flash must hold the response valid until the loader accepts it.

A load ends in one of two ways. It succeeds when the target reports configuration-done at a word boundary; the block then issues a fixed number of extra clock pulses for device start-up. It fails when the target's status pin drops, or when the last word of the region has been sent without a done report. The block drives three indicators: loading, done and error.

Top module: `cfg_flash_loader`

## Requirements
- R1: A load starts when reset is released, and again on every high-to-low transition of `reconfig_n`, including one that arrives during a load. A new load abandons the old one and does not wait for it.
- R2: Each load holds `tgt_nconfig` low for at least `CFG_LOW_CYC` consecutive cycles. No `tgt_dclk` rising edge occurs while `tgt_nstatus` is low.
- R3: `page_sel` is sampled at load start. A value of 0 reads words from `FACT_LO` up to `FACT_HI`, and a value of 1 reads words from `USER_LO` up to `USER_HI`. Byte addresses step by 2 from the even base, and no request leaves the selected region.
- R4: Each flash word is sent as bits [7:0] and then bits [15:8], one byte per `tgt_dclk` rising edge. `tgt_data` does not change in any cycle in which `tgt_dclk` is high.
- R5: Once raised, `flash_req_valid` stays high with a stable address until `flash_req_ready` is seen. A word is taken only in a cycle where both `flash_rsp_valid` and `flash_rsp_ready` are high.
- R6: `led_loading` is high from load start until the load ends. It is high at every `tgt_dclk` rising edge and low once the load succeeds or fails.
- R7: If `tgt_conf_done` is high when a word has finished sending, exactly `INIT_DCLKS` further `tgt_dclk` rising edges follow. No more words are sent, and the clock then stays low.
- R8: `led_done` equals `tgt_conf_done` delayed by one cycle.
- R9: If `tgt_nstatus` drops after the target has reported ready, the load fails within one cycle: `led_error` rises, `led_loading` falls, and no further clock edge or byte follows.
- R10: If the last word of the region has been sent and `tgt_conf_done` is still low, the load fails with `led_error` high, after exactly the region's full byte count.
- R11: After a failure the block stays quiet until the next press or reset: no flash request, no clock edge, `tgt_nconfig` high and `led_error` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts a load |
| reconfig_n | input | 1 | Active-low reconfigure button |
| page_sel | input | 1 | Image region: 0 factory, 1 user |
| flash_req_valid | output | 1 | Read request valid |
| flash_req_ready | input | 1 | Flash accepts the request |
| flash_req_addr | output | ADDR_W | Byte address of the requested word |
| flash_rsp_valid | input | 1 | Read data valid |
| flash_rsp_ready | output | 1 | Loader accepts read data |
| flash_rsp_data | input | 16 | Read data word |
| tgt_nconfig | output | 1 | Target configuration reset, active low |
| tgt_nstatus | input | 1 | Target ready/status, low means reset or error |
| tgt_conf_done | input | 1 | Target configuration complete |
| tgt_data | output | 8 | Configuration byte |
| tgt_dclk | output | 1 | Configuration clock |
| led_loading | output | 1 | Load in progress |
| led_done | output | 1 | Configuration succeeded |
| led_error | output | 1 | Load failed |

## Verification
A sequencer stuck in the wrong state shows at the ports within a few cycles. The clock stops while loading stays high, a request stays pending, or the error indicator lights after a byte count different from the one the done threshold implies. A wrong address register shows on the first mismatched byte, because every flash word is a distinct function of its address. The bench checks each byte the moment it is clocked out. A word-to-byte sequencing fault shows as a swapped or repeated byte at the first word. A miscounted start-up tail shows as the wrong number of extra edges as soon as the load ends.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [3:0] {
    ST_START,
    ST_HOLD,
    ST_WAITST,
    ST_FETCH,
    ST_RECV,
    ST_SEND,
    ST_INIT,
    ST_DONE,
    ST_FAIL
  } ldr_state_e;
endpackage

// File: rtl/cfg_ldr_addr.sv
module cfg_ldr_addr #(
  parameter int          ADDR_W  = 26,
  parameter logic [31:0] FACT_LO = 32'h0002_0000,
  parameter logic [31:0] FACT_HI = 32'h014B_FFFF,
  parameter logic [31:0] USER_LO = 32'h0200_0000,
  parameter logic [31:0] USER_HI = 32'h0349_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              page,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] F_FIRST = FACT_LO[ADDR_W-1:0] & ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] F_LAST  = FACT_HI[ADDR_W-1:0] & ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] U_FIRST = USER_LO[ADDR_W-1:0] & ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] U_LAST  = USER_HI[ADDR_W-1:0] & ~ADDR_W'(1);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      addr  <= F_FIRST;
    end else if (start) begin
      sel_q <= page;
      addr  <= page ? U_FIRST : F_FIRST;
    end else if (step) begin
      addr  <= addr + ADDR_W'(2);
    end
  end

  assign last = (addr == (sel_q ? U_LAST : F_LAST));
endmodule

// File: rtl/cfg_ldr_shift.sv
module cfg_ldr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load_word,
  input  logic                load_pulse,
  input  logic [2*BYTE_W-1:0] word,
  output logic [BYTE_W-1:0]   data,
  output logic                dclk,
  output logic                busy
);
  logic [BYTE_W-1:0] hi_q;
  logic              hi_pend;
  logic              phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0; hi_q <= '0; hi_pend <= 1'b0;
      phase <= 1'b0; dclk <= 1'b0; busy <= 1'b0;
    end else if (clear) begin
      data <= '0; hi_pend <= 1'b0;
      phase <= 1'b0; dclk <= 1'b0; busy <= 1'b0;
    end else if (load_word) begin
      data    <= word[BYTE_W-1:0];
      hi_q    <= word[2*BYTE_W-1:BYTE_W];
      hi_pend <= 1'b1;
      phase   <= 1'b0;
      dclk    <= 1'b0;
      busy    <= 1'b1;
    end else if (load_pulse) begin
      hi_pend <= 1'b0;
      phase   <= 1'b0;
      dclk    <= 1'b0;
      busy    <= 1'b1;
    end else if (busy) begin
      if (!phase) begin
        dclk  <= 1'b1;
        phase <= 1'b1;
      end else begin
        dclk  <= 1'b0;
        phase <= 1'b0;
        if (hi_pend) begin
          data    <= hi_q;
          hi_pend <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_ldr_seq.sv
module cfg_ldr_seq
  import cfg_ldr_pkg::*;
#(
  parameter int CFG_LOW_CYC = 64,
  parameter int INIT_DCLKS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press,
  input  logic       nstatus,
  input  logic       conf_done,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic       shift_busy,
  input  logic       addr_last,
  output ldr_state_e state,
  output logic       start,
  output logic       step,
  output logic       clear,
  output logic       load_word,
  output logic       load_pulse,
  output logic       req_valid,
  output logic       rsp_ready,
  output logic       nconfig,
  output logic       loading,
  output logic       failed
);
  localparam int CNT_W = $clog2(CFG_LOW_CYC + INIT_DCLKS + 2) + 1;
  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(CFG_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_DCLKS);

  ldr_state_e       nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    nxt        = state;
    cnt_d      = cnt_q;
    start      = 1'b0;
    step       = 1'b0;
    clear      = 1'b0;
    load_word  = 1'b0;
    load_pulse = 1'b0;
    req_valid  = 1'b0;
    rsp_ready  = 1'b0;
    unique case (state)
      ST_START: begin
        start = 1'b1;
        clear = 1'b1;
        cnt_d = '0;
        nxt   = ST_HOLD;
      end
      ST_HOLD: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q >= LOW_END) nxt = ST_WAITST;
      end
      ST_WAITST: if (nstatus) nxt = ST_FETCH;
      ST_FETCH: begin
        req_valid = 1'b1;
        if (!nstatus) nxt = ST_FAIL;
        else if (req_ready) nxt = ST_RECV;
      end
      ST_RECV: begin
        rsp_ready = 1'b1;
        if (!nstatus) nxt = ST_FAIL;
        else if (rsp_valid) begin
          load_word = 1'b1;
          nxt       = ST_SEND;
        end
      end
      ST_SEND: begin
        if (!nstatus) begin
          clear = 1'b1;
          nxt   = ST_FAIL;
        end else if (!shift_busy) begin
          if (conf_done) begin
            cnt_d = '0;
            nxt   = ST_INIT;
          end else if (addr_last) begin
            nxt = ST_FAIL;
          end else begin
            step = 1'b1;
            nxt  = ST_FETCH;
          end
        end
      end
      ST_INIT: begin
        if (!nstatus) begin
          clear = 1'b1;
          nxt   = ST_FAIL;
        end else if (!shift_busy) begin
          if (cnt_q == INIT_END) nxt = ST_DONE;
          else begin
            load_pulse = 1'b1;
            cnt_d      = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_DONE: nxt = ST_DONE;
      ST_FAIL: nxt = ST_FAIL;
      default: nxt = ST_FAIL;
    endcase
    if (press) begin
      nxt        = ST_START;
      clear      = 1'b1;
      load_word  = 1'b0;
      load_pulse = 1'b0;
      step       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
      cnt_q <= '0;
    end else begin
      state <= nxt;
      cnt_q <= cnt_d;
    end
  end

  assign nconfig = !(state == ST_START || state == ST_HOLD);
  assign loading = !(state == ST_DONE || state == ST_FAIL);
  assign failed  = (state == ST_FAIL);
endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader
  import cfg_ldr_pkg::*;
#(
  parameter int          ADDR_W      = 26,
  parameter logic [31:0] FACT_LO     = 32'h0002_0000,
  parameter logic [31:0] FACT_HI     = 32'h014B_FFFF,
  parameter logic [31:0] USER_LO     = 32'h0200_0000,
  parameter logic [31:0] USER_HI     = 32'h0349_FFFF,
  parameter int          CFG_LOW_CYC = 64,
  parameter int          INIT_DCLKS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reconfig_n,
  input  logic              page_sel,
  output logic              flash_req_valid,
  input  logic              flash_req_ready,
  output logic [ADDR_W-1:0] flash_req_addr,
  input  logic              flash_rsp_valid,
  output logic              flash_rsp_ready,
  input  logic [15:0]       flash_rsp_data,
  output logic              tgt_nconfig,
  input  logic              tgt_nstatus,
  input  logic              tgt_conf_done,
  output logic [7:0]        tgt_data,
  output logic              tgt_dclk,
  output logic              led_loading,
  output logic              led_done,
  output logic              led_error
);
  logic       btn_q, press;
  logic       start, step, clear, load_word, load_pulse, busy, last;
  ldr_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q    <= 1'b1;
      led_done <= 1'b0;
    end else begin
      btn_q    <= reconfig_n;
      led_done <= tgt_conf_done;
    end
  end

  assign press = btn_q & ~reconfig_n;

  cfg_ldr_seq #(
    .CFG_LOW_CYC(CFG_LOW_CYC),
    .INIT_DCLKS (INIT_DCLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .press     (press),
    .nstatus   (tgt_nstatus),
    .conf_done (tgt_conf_done),
    .req_ready (flash_req_ready),
    .rsp_valid (flash_rsp_valid),
    .shift_busy(busy),
    .addr_last (last),
    .state     (state),
    .start     (start),
    .step      (step),
    .clear     (clear),
    .load_word (load_word),
    .load_pulse(load_pulse),
    .req_valid (flash_req_valid),
    .rsp_ready (flash_rsp_ready),
    .nconfig   (tgt_nconfig),
    .loading   (led_loading),
    .failed    (led_error)
  );

  cfg_ldr_addr #(
    .ADDR_W (ADDR_W),
    .FACT_LO(FACT_LO),
    .FACT_HI(FACT_HI),
    .USER_LO(USER_LO),
    .USER_HI(USER_HI)
  ) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .page (page_sel),
    .step (step),
    .addr (flash_req_addr),
    .last (last)
  );

  cfg_ldr_shift #(
    .BYTE_W(8)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .load_word (load_word),
    .load_pulse(load_pulse),
    .word      (flash_rsp_data),
    .data      (tgt_data),
    .dclk      (tgt_dclk),
    .busy      (busy)
  );
endmodule

// File: rtl/cfg_flash_loader_chk.sv
module cfg_flash_loader_chk #(
  parameter int          ADDR_W      = 26,
  parameter logic [31:0] FACT_LO     = 32'h0002_0000,
  parameter logic [31:0] FACT_HI     = 32'h014B_FFFF,
  parameter logic [31:0] USER_LO     = 32'h0200_0000,
  parameter logic [31:0] USER_HI     = 32'h0349_FFFF,
  parameter int          CFG_LOW_CYC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reconfig_n,
  input logic              flash_req_valid,
  input logic              flash_req_ready,
  input logic [ADDR_W-1:0] flash_req_addr,
  input logic              tgt_nconfig,
  input logic              tgt_nstatus,
  input logic              tgt_conf_done,
  input logic [7:0]        tgt_data,
  input logic              tgt_dclk,
  input logic              led_loading,
  input logic              led_done,
  input logic              led_error
);
  localparam logic [ADDR_W-1:0] F_LO = FACT_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] F_HI = FACT_HI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] U_LO = USER_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] U_HI = USER_HI[ADDR_W-1:0];

  logic [15:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (tgt_nconfig) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
  end

  p_low_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_nconfig) |-> (low_run >= 16'(CFG_LOW_CYC)));

  p_no_clk_unready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_dclk && !tgt_nstatus) |=> !tgt_dclk);

  p_addr_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req_valid |-> ((flash_req_addr >= F_LO && flash_req_addr <= F_HI) ||
                         (flash_req_addr >= U_LO && flash_req_addr <= U_HI)));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_dclk |-> $stable(tgt_data));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req_valid && !flash_req_ready && tgt_nstatus && reconfig_n)
      |=> (flash_req_valid && $stable(flash_req_addr)));

  p_clk_while_loading_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_dclk |-> led_loading);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (led_done == $past(tgt_conf_done)));

  p_quiet_after_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    led_error |-> (!flash_req_valid && !tgt_dclk && !led_loading && tgt_nconfig));
endmodule

bind cfg_flash_loader cfg_flash_loader_chk #(
  .ADDR_W     (ADDR_W),
  .FACT_LO    (FACT_LO),
  .FACT_HI    (FACT_HI),
  .USER_LO    (USER_LO),
  .USER_HI    (USER_HI),
  .CFG_LOW_CYC(CFG_LOW_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reconfig_n     (reconfig_n),
  .flash_req_valid(flash_req_valid),
  .flash_req_ready(flash_req_ready),
  .flash_req_addr (flash_req_addr),
  .tgt_nconfig    (tgt_nconfig),
  .tgt_nstatus    (tgt_nstatus),
  .tgt_conf_done  (tgt_conf_done),
  .tgt_data       (tgt_data),
  .tgt_dclk       (tgt_dclk),
  .led_loading    (led_loading),
  .led_done       (led_done),
  .led_error      (led_error)
);

// File: tb/sim_cfg_flash_loader.sv
module sim_cfg_flash_loader;
  localparam int          AW     = 8;
  localparam logic [31:0] F_LO   = 32'h20;
  localparam logic [31:0] F_HI   = 32'h3F;
  localparam logic [31:0] U_LO   = 32'h80;
  localparam logic [31:0] U_HI   = 32'h9F;
  localparam int          LOWC   = 4;
  localparam int          INITC  = 3;
  localparam int          PAGE_B = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, reconfig_n = 1'b1, page_sel = 1'b0;
  logic          flash_req_valid, flash_req_ready = 1'b0;
  logic [AW-1:0] flash_req_addr;
  logic          flash_rsp_valid = 1'b0, flash_rsp_ready;
  logic [15:0]   flash_rsp_data = '0;
  logic          tgt_nconfig, tgt_nstatus = 1'b0, tgt_conf_done = 1'b0;
  logic [7:0]    tgt_data;
  logic          tgt_dclk, led_loading, led_done, led_error;

  cfg_flash_loader #(
    .ADDR_W(AW), .FACT_LO(F_LO), .FACT_HI(F_HI), .USER_LO(U_LO), .USER_HI(U_HI),
    .CFG_LOW_CYC(LOWC), .INIT_DCLKS(INITC)
  ) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  int cd_at = 1000, fault_at = 0, exp_page = 0;
  int rx_cnt = 0, extra = 0, mism = 0, viol_st = 0, viol_load = 0;
  int st_cnt = 0, low_run = 0, min_low = 1000000, req_cnt = 0;
  logic dclk_prev = 1'b0;
  bit rsp_take = 0, req_take = 0, fl_busy = 0;
  int lat = 0;
  logic [AW-1:0] raddr = '0;

  function automatic logic [15:0] flash_word(logic [AW-1:0] a);
    return {a ^ 8'h5A, a + 8'h13};
  endfunction

  // target and flash models, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!tgt_nconfig) begin
      tgt_nstatus = 1'b0; st_cnt = 0; rx_cnt = 0; extra = 0; mism = 0;
      low_run++;
      rsp_take = 0; req_take = 0; fl_busy = 0; flash_rsp_valid = 1'b0;
    end else begin
      if (low_run > 0) begin
        if (low_run < min_low) min_low = low_run;
        low_run = 0;
      end
      if (st_cnt < 3) st_cnt++;
      if (tgt_dclk && !dclk_prev) begin
        if (!tgt_nstatus) viol_st++;
        if (!led_loading) viol_load++;
        if (tgt_conf_done) extra++;
        else begin
          logic [AW-1:0] a;
          logic [7:0] e;
          a = (exp_page != 0 ? U_LO[AW-1:0] : F_LO[AW-1:0]) + AW'(2 * (rx_cnt / 2));
          e = (rx_cnt % 2 == 1) ? (a ^ 8'h5A) : (a + 8'h13);
          if (tgt_data !== e) mism++;
          rx_cnt++;
        end
      end
      tgt_nstatus = (st_cnt >= 3) && !(fault_at > 0 && rx_cnt >= fault_at);
      // flash
      if (rsp_take) begin flash_rsp_valid = 1'b0; rsp_take = 0; end
      if (req_take) begin fl_busy = 1; lat = int'(raddr % 3); req_take = 0; end
      if (fl_busy && !flash_rsp_valid) begin
        if (lat == 0) begin
          flash_rsp_valid = 1'b1; flash_rsp_data = flash_word(raddr); fl_busy = 0;
        end else lat--;
      end
    end
    tgt_conf_done = tgt_nconfig && (rx_cnt >= cd_at);
    dclk_prev = tgt_dclk;
    flash_req_ready = (cyc % 3 != 1);
    if (tgt_nconfig) begin
      if (flash_rsp_valid && flash_rsp_ready) rsp_take = 1;
      if (flash_req_valid && flash_req_ready) begin
        req_take = 1; raddr = flash_req_addr; req_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic press();
    @(negedge clk) reconfig_n = 1'b0;
    @(negedge clk) reconfig_n = 1'b1;
  endtask

  task automatic wait_end();
    int n = 0;
    while (led_loading && n < 4000) begin @(negedge clk); n++; end
    chk("R6 load ends (loading low)", int'(led_loading), 0);
  endtask

  task automatic run(input int pg, input int cd, input bit use_press);
    int exp_b;
    bit exp_err;
    exp_page = pg; page_sel = pg[0]; cd_at = cd; fault_at = 0;
    min_low = 1000000; viol_st = 0; viol_load = 0;
    if (use_press) press();
    wait_end();
    exp_err = (cd > PAGE_B);
    exp_b   = exp_err ? PAGE_B : cd;
    chk($sformatf("R3 R4 byte count page %0d cd %0d", pg, cd), rx_cnt, exp_b);
    chk($sformatf("R3 R4 byte values page %0d cd %0d", pg, cd), mism, 0);
    chk("R10 error flag", int'(led_error), int'(exp_err));
    chk("R8 done flag", int'(led_done), int'(!exp_err));
    chk("R7 start-up clocks", extra, exp_err ? 0 : INITC);
    chk("R2 no clock while not ready", viol_st, 0);
    chk("R6 loading at every clock", viol_load, 0);
    chk("R2 config pulse length", int'(min_low >= LOWC), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    page_sel = 1'b0; cd_at = 10;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset starts load: nconfig", int'(tgt_nconfig), 0);
    chk("R6 reset loading", int'(led_loading), 1);
    chk("R5 reset no request", int'(flash_req_valid), 0);
    chk("R9 reset no error", int'(led_error), 0);
    chk("R4 reset clock low", int'(tgt_dclk), 0);
    run(0, 10, 1'b0);

    // near-exhaustive sweep of done position over both pages (R3 R7 R10)
    for (int pg = 0; pg < 2; pg++)
      for (int cd = 2; cd <= PAGE_B + 2; cd += 2)
        run(pg, cd, 1'b1);

    // R9: status drop mid-load
    exp_page = 0; page_sel = 1'b0; cd_at = 1000; fault_at = 6;
    press();
    wait_end();
    chk("R9 status fault error", int'(led_error), 1);
    chk("R9 bytes stop at fault", rx_cnt, 6);
    begin
      int rq, rx;
      rq = req_cnt; rx = rx_cnt;
      repeat (60) @(negedge clk);
      chk("R11 no requests after fail", req_cnt - rq, 0);
      chk("R11 no bytes after fail", rx_cnt - rx, 0);
      chk("R11 nconfig high after fail", int'(tgt_nconfig), 1);
      chk("R11 error held", int'(led_error), 1);
    end

    // R1: press during a load restarts on the new page
    exp_page = 0; page_sel = 1'b0; cd_at = 1000; fault_at = 0;
    press();
    while (rx_cnt < 8) @(posedge clk);
    exp_page = 1; page_sel = 1'b1; cd_at = 12;
    press();
    wait_end();
    chk("R1 restart byte count", rx_cnt, 12);
    chk("R1 restart byte values", mism, 0);
    chk("R1 restart done", int'(led_done), 1);
    chk("R7 restart start-up clocks", extra, INITC);

    finish_run();
  end
endmodule